// File: doc/BRIEF.md
# Cold Load Pickup Sequencer

This block watches a feeder breaker and decides when the feeder is re-energising a load that has gone cold. Once the breaker has stayed open longer than a programmable cold time, the block raises an active flag. Downstream overcurrent stages read that flag and switch to raised pickup levels and delays while the load settles. The flag is held for a programmable reset time, counted from the moment the breaker closes. After that the block returns to idle and the normal settings apply again. A fast-reset request shortens the hold to a separate, shorter preset.

The breaker state comes from one of two sources. One is a load-present flag, which is high when any phase current exceeds 0.04 of rated current; no load current is taken as an open breaker. The other is a normally closed auxiliary contact, which reads 1 while the breaker is open. An enable gates the whole function and a block input forces it inactive. An external initiate can start the sequence without waiting out the cold time.

All timing is driven by a one-cycle millisecond tick. The three presets are 22-bit counts of milliseconds: cold time and reset time each cover 0 to 4000 s, and the short reset time covers 0 to 600 s. Control and status pins are plain levels with no handshake.

Top module: `cold_load_seq`

## Requirements
- R1: The flag arms only after the selected breaker source has shown open for more than `cold_preset` ticks in a row. The block arms on the tick that finds the elapsed count already equal to or above the preset. If the breaker closes before arming, the block returns to idle and the flag stays low.
- R2: Once armed, `active` is high. After the breaker closes, `active` stays high until `reset_preset` ticks have elapsed, then returns low in the idle state.
- R3: With `mode_aux`=0 the breaker counts as open when `load_present`=0, and `brk_nc_aux` is ignored. With `mode_aux`=1 the breaker counts as open when `brk_nc_aux`=1, and `load_present` is ignored.
- R4: If `fast_rst_req` is high for at least one cycle while `active` is high, the hold after closing ends once `short_preset` ticks have elapsed instead of `reset_preset`.
- R5: Timer counts advance only on cycles where `tick_ms` is high. With no ticks, the state does not progress by time.
- R6: If the breaker reopens during the post-closing hold, `active` drops and the block restarts open timing from zero.
- R7: A synchronous `rst`, or `enable`=0, puts the block in idle with `active` low and all counts cleared. A later sequence then times from zero.
- R8: While `block` is high, the block is held in idle and `active` is low on the following cycle.
- R9: An `init_ext` pulse in idle or during open timing arms the flag at once, without waiting out the cold time.
- R10: `dbg_state` encodes 0 = idle, 1 = open timing, 2 = armed with the breaker still open, and 3 = closed and holding. `active` is high exactly in states 2 and 3.
- R11: A preset of zero is legal. A zero cold time arms on the first tick of open timing. A zero hold time ends the hold on the cycle after entering state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| load_present | input | 1 | High when any phase current is above 0.04 of rated current |
| brk_nc_aux | input | 1 | Normally closed breaker auxiliary contact, 1 = open |
| mode_aux | input | 1 | Breaker source: 0 = load flag, 1 = auxiliary contact |
| enable | input | 1 | Function enable |
| block | input | 1 | Forces the function inactive |
| init_ext | input | 1 | External start of the sequence |
| fast_rst_req | input | 1 | Request for the short hold time |
| cold_preset | input | CNT_W | Minimum open time in ticks |
| reset_preset | input | CNT_W | Hold time after closing in ticks |
| short_preset | input | CNT_W | Fast-reset hold time in ticks |
| active | output | 1 | Cold load flag for the overcurrent stages |
| dbg_state | output | 2 | Sequencer state, encoded as in R10 |

## Verification
The bench targets the edges of each timer. It checks that the block is still timing after exactly `cold_preset` ticks and arms on the next tick; a design using a plain "equal or more" comparison would arm one tick early. It checks that a reopened breaker restarts open timing from zero, and that disabling and re-enabling also clears the count; a design that keeps the stale count would arm almost at once. It also covers a one-cycle fast-reset request, which must end the hold after the short preset rather than the full one; a design without a sticky latch would forget the request and hold for the full time. Zero presets and a block input asserted while the flag is high complete the set.

// File: rtl/cold_load_pkg.sv
package cold_load_pkg;
  localparam int unsigned CLP_CNT_W = 22;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_ARMED = 2'd2,
    ST_RUN   = 2'd3
  } clp_state_e;
endpackage

// File: rtl/clp_brk_src.sv
module clp_brk_src (
  input  logic mode_aux,
  input  logic load_present,
  input  logic brk_nc_aux,
  output logic brk_open
);
  // R3: source select; the unselected input has no effect
  always_comb begin
    if (mode_aux) brk_open = brk_nc_aux;
    else          brk_open = ~load_present;
  end
endmodule

// File: rtl/clp_tick_cnt.sv
module clp_tick_cnt #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Saturating millisecond counter; clear wins over increment
  always_ff @(posedge clk) begin
    if (rst || clr)               cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clp_fsm.sv
module clp_fsm
  import cold_load_pkg::*;
#(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             block,
  input  logic             brk_open,
  input  logic             init_req,
  input  logic             fast_req,
  input  logic             tick_ms,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cold_preset,
  input  logic [CNT_W-1:0] reset_preset,
  input  logic [CNT_W-1:0] short_preset,
  output clp_state_e       state,
  output logic             cnt_inc,
  output logic             cnt_clr,
  output logic             flag
);
  clp_state_e       nxt;
  logic             fast_q;
  logic             use_short;
  logic [CNT_W-1:0] hold_limit;
  logic             timing;

  assign flag       = (state == ST_ARMED) || (state == ST_RUN);
  assign timing     = (state == ST_OPEN) || (state == ST_RUN);
  assign use_short  = fast_q || (fast_req && flag);
  assign hold_limit = use_short ? short_preset : reset_preset;

  always_comb begin
    nxt = state;
    if (!enable || block) begin
      nxt = ST_IDLE;                                  // R7, R8
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (init_req)      nxt = ST_ARMED;           // R9
          else if (brk_open) nxt = ST_OPEN;
        end
        ST_OPEN: begin
          if (init_req)                            nxt = ST_ARMED;
          else if (!brk_open)                      nxt = ST_IDLE;   // R1
          else if (tick_ms && cnt >= cold_preset)  nxt = ST_ARMED;  // R1, R5
        end
        ST_ARMED: begin
          if (!brk_open) nxt = ST_RUN;                 // R2
        end
        ST_RUN: begin
          if (brk_open)                nxt = ST_OPEN;  // R6
          else if (cnt >= hold_limit)  nxt = ST_IDLE;  // R2, R4, R11
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign cnt_inc = tick_ms && timing;
  assign cnt_clr = (nxt != state) || !timing;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      fast_q <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != ST_ARMED && nxt != ST_RUN) fast_q <= 1'b0;
      else if (fast_req && flag)            fast_q <= 1'b1;   // R4
    end
  end
endmodule

// File: rtl/cold_load_seq.sv
module cold_load_seq
  import cold_load_pkg::*;
#(
  parameter int unsigned CNT_W = CLP_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             load_present,
  input  logic             brk_nc_aux,
  input  logic             mode_aux,
  input  logic             enable,
  input  logic             block,
  input  logic             init_ext,
  input  logic             fast_rst_req,
  input  logic [CNT_W-1:0] cold_preset,
  input  logic [CNT_W-1:0] reset_preset,
  input  logic [CNT_W-1:0] short_preset,
  output logic             active,
  output logic [1:0]       dbg_state
);
  logic             brk_open;
  logic             cnt_inc;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;
  clp_state_e       state;

  clp_brk_src u_src (
    .mode_aux     (mode_aux),
    .load_present (load_present),
    .brk_nc_aux   (brk_nc_aux),
    .brk_open     (brk_open)
  );

  clp_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (cnt)
  );

  clp_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .block        (block),
    .brk_open     (brk_open),
    .init_req     (init_ext),
    .fast_req     (fast_rst_req),
    .tick_ms      (tick_ms),
    .cnt          (cnt),
    .cold_preset  (cold_preset),
    .reset_preset (reset_preset),
    .short_preset (short_preset),
    .state        (state),
    .cnt_inc      (cnt_inc),
    .cnt_clr      (cnt_clr),
    .flag         (active)
  );

  assign dbg_state = state;   // R10
endmodule

// File: rtl/cold_load_chk.sv
module cold_load_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       block,
  input logic       tick_ms,
  input logic       init_ext,
  input logic       active,
  input logic [1:0] dbg_state
);
  // R8
  block_clears_chk: assert property (@(posedge clk) disable iff (rst)
    block |=> !active);

  // R7
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (dbg_state == 2'd0));

  // R1
  arm_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == 2'd2 && $past(dbg_state) != 2'd2) |->
      ($past(dbg_state) == 2'd1 || $past(dbg_state) == 2'd0));

  // R5
  arm_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == 2'd2 && $past(dbg_state) == 2'd1) |->
      ($past(tick_ms) || $past(init_ext)));

  // R6
  run_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == 2'd3) |=> (dbg_state != 2'd2));

  // R10
  flag_state_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> (dbg_state == 2'd2 || dbg_state == 2'd3));
endmodule

bind cold_load_seq cold_load_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .block     (block),
  .tick_ms   (tick_ms),
  .init_ext  (init_ext),
  .active    (active),
  .dbg_state (dbg_state)
);

// File: tb/tb_cold_load_seq.sv
module tb_cold_load_seq;
  localparam int unsigned W = 22;

  logic clk = 1'b0;
  logic rst, tick_ms, load_present, brk_nc_aux, mode_aux;
  logic enable, block, init_ext, fast_rst_req;
  logic [W-1:0] cold_preset, reset_preset, short_preset;
  logic active;
  logic [1:0] dbg_state;

  int ntests = 0;
  int nfail  = 0;

  always #2 clk = ~clk;   // 250 MHz

  cold_load_seq #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .load_present(load_present),
    .brk_nc_aux(brk_nc_aux), .mode_aux(mode_aux), .enable(enable),
    .block(block), .init_ext(init_ext), .fast_rst_req(fast_rst_req),
    .cold_preset(cold_preset), .reset_preset(reset_preset),
    .short_preset(short_preset), .active(active), .dbg_state(dbg_state)
  );

  typedef struct packed {
    logic       mode;
    logic       load;
    logic       nc;
    logic       init;
    logic       fast;
    logic [3:0] ticks;
    logic       act;
    logic [1:0] st;
  } vec_t;

  // presets: cold 3, hold 4, short 1; states per R10
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd5,1'b0,2'd0},  // R3 load present: closed
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,1'b0,2'd1},  // R1 open timing starts
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,1'b0,2'd1},  // R1 equal to preset: not yet
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,1'b1,2'd2},  // R1 armed
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,1'b1,2'd3},  // R2 closed, holding
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd3,1'b1,2'd3},  // R2 still holding
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd1,1'b0,2'd0},  // R2 hold over
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd2,1'b0,2'd0},  // R3 aux mode ignores load
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd0,1'b0,2'd1},  // R3 aux contact open
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd4,1'b1,2'd2},  // R1 armed via aux
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,1'b1,2'd3},  // R2 closed
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'd0,1'b1,2'd3},  // R4 fast request pulse
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,1'b0,2'd0},  // R4 short hold done
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd4,1'b1,2'd2},  // R1 re-armed
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'd2,1'b1,2'd3},  // R2 holding
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd0,1'b0,2'd1},  // R6 reopen drops flag
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd3,1'b0,2'd1},  // R6 count restarted
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,1'b0,2'd0},  // R1 closed before arming
    '{1'b0,1'b1,1'b0,1'b1,1'b0,4'd0,1'b1,2'd3},  // R9 initiate arms at once
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd4,1'b0,2'd0}   // R9 hold then idle
  };

  task automatic tick_once();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick_once();
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic exp_act, logic [1:0] exp_st);
    ntests++;
    if (active !== exp_act || dbg_state !== exp_st) begin
      nfail++;
      $display("FAIL %s: active=%0b state=%0d, expected active=%0b state=%0d",
               req, active, dbg_state, exp_act, exp_st);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; tick_ms = 1'b0; load_present = 1'b1; brk_nc_aux = 1'b0;
    mode_aux = 1'b0; enable = 1'b1; block = 1'b0; init_ext = 1'b0;
    fast_rst_req = 1'b0;
    cold_preset = 22'd3; reset_preset = 22'd4; short_preset = 22'd1;
    settle(3);
    rst = 1'b0;
    settle(1);
    chk("R7 reset state", 1'b0, 2'd0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode_aux = VECS[v].mode; load_present = VECS[v].load;
      brk_nc_aux = VECS[v].nc; init_ext = VECS[v].init;
      fast_rst_req = VECS[v].fast;
      ticks(int'(VECS[v].ticks));
      settle(2);
      chk($sformatf("vector %0d", v), VECS[v].act, VECS[v].st);
    end
    init_ext = 1'b0; fast_rst_req = 1'b0; mode_aux = 1'b0; load_present = 1'b1;

    // R5: no ticks, no progress
    @(negedge clk) load_present = 1'b0;
    settle(40);
    chk("R5 open without ticks", 1'b0, 2'd1);

    // R8: block while armed
    ticks(4);
    settle(1);
    chk("R8 armed before block", 1'b1, 2'd2);
    @(negedge clk) block = 1'b1;
    settle(1);
    chk("R8 block drops flag", 1'b0, 2'd0);
    ticks(6);
    chk("R8 held idle under block", 1'b0, 2'd0);
    @(negedge clk) block = 1'b0;
    settle(1);
    chk("R8 release resumes timing", 1'b0, 2'd1);

    // R7: disable clears the count
    ticks(3);
    @(negedge clk) enable = 1'b0;
    settle(2);
    chk("R7 disable to idle", 1'b0, 2'd0);
    @(negedge clk) enable = 1'b1;
    ticks(1);
    settle(1);
    chk("R7 count cleared by disable", 1'b0, 2'd1);

    // R7: synchronous reset during hold
    ticks(3);
    @(negedge clk) load_present = 1'b1;
    settle(2);
    chk("R2 hold entered", 1'b1, 2'd3);
    @(negedge clk) rst = 1'b1;
    settle(1);
    rst = 1'b0;
    settle(1);
    chk("R7 reset mid hold", 1'b0, 2'd0);

    // R11: zero presets
    @(negedge clk) begin
      cold_preset = '0; reset_preset = '0;
      load_present = 1'b0;
    end
    settle(2);
    chk("R11 open with zero cold time", 1'b0, 2'd1);
    ticks(1);
    settle(1);
    chk("R11 arms on first tick", 1'b1, 2'd2);
    @(negedge clk) load_present = 1'b1;
    settle(1);
    chk("R11 hold entered", 1'b1, 2'd3);
    settle(1);
    chk("R11 zero hold ends", 1'b0, 2'd0);

    // R2: large preset, long hold without ticks
    @(negedge clk) begin
      reset_preset = 22'd4000000; load_present = 1'b0;
    end
    ticks(1);
    @(negedge clk) load_present = 1'b1;
    settle(30);
    chk("R2 long hold persists", 1'b1, 2'd3);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule